// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer

This block is a small, fully associative cache of page mappings that sits between a requesting core and memory. A lookup presents a virtual address, a process identifier and a read/write flag. The upper page-number field of the address, together with the identifier, is compared against every stored mapping at once. On a match, the page number is swapped for the stored frame number, and the in-page offset is carried across unchanged. On no match, a miss is raised so that an external table walker can fetch the mapping and write it in through the fill port.

Each stored mapping records its owning process. Because of this, a process switch needs no flush, and a mapping left behind by another process can never produce a hit. Two flush commands remove mappings: one clears everything, and the other clears only the mappings of one chosen process. Each mapping also carries a write-protect flag and a dirty flag. A write to a protected page is refused and reported as a fault. A write to a writable page marks the mapping dirty.

Top module: `ptag_tlb`

## Requirements
- R1: The 16-bit virtual address holds the page number in bits 15:10 and the offset in bits 9:0. On a hit the 16-bit physical address is the 6-bit stored frame in bits 15:10 followed by the unchanged offset bits 9:0.
- R2: A lookup is accepted at a rising edge with `lk_valid` high, and its response appears on the `rs_*` outputs right after that edge, with `rs_valid` high for exactly that one cycle. `rs_valid` is low after any edge without a lookup.
- R3: A hit requires a valid mapping whose page number and process identifier both equal the lookup's. The same page held for a different process does not hit.
- R4: A response without a hit has `rs_miss`=1, `rs_hit`=0, `rs_fault`=0, `rs_dirty`=0 and `rs_paddr`=0.
- R5: A write hit on a mapping whose write-protect flag is set gives `rs_hit`=1 and `rs_fault`=1, and it leaves the dirty flag clear. A read hit on such a mapping gives no fault.
- R6: A write hit on a writable mapping sets its dirty flag, and the response already reports `rs_dirty`=1. Later read hits report the stored dirty flag. A fill always stores the dirty flag as 0.
- R7: A fill whose page number and identifier equal an existing valid mapping overwrites that mapping. Otherwise it takes the lowest-numbered empty slot. When every slot is full, it replaces the slot named by a replacement pointer. That pointer starts at 0 after reset and steps by one, wrapping after the last slot, only when it is used.
- R8: `flush_all` invalidates every mapping.
- R9: `flush_pid_en` invalidates only the mappings whose identifier equals `flush_pid`. Mappings of other processes keep hitting.
- R10: A lookup answers from the contents held before the edge that accepts it, even if a fill, a flush or a dirty update lands at that same edge. A fill issued in the same cycle as a flush is kept valid.
- R11: After reset every slot is empty, the replacement pointer is 0, and all `rs_*` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 16 | Virtual address to translate |
| lk_pid | input | 8 | Identifier of the requesting process |
| fill_en | input | 1 | Write one mapping this cycle |
| fill_vpn | input | 6 | Virtual page number of the new mapping |
| fill_pid | input | 8 | Process owning the new mapping |
| fill_frame | input | 6 | Physical frame of the new mapping |
| fill_wprot | input | 1 | New mapping is write-protected |
| flush_all | input | 1 | Invalidate every mapping |
| flush_pid_en | input | 1 | Invalidate the mappings of one process |
| flush_pid | input | 8 | Process whose mappings are invalidated |
| rs_valid | output | 1 | Response present this cycle |
| rs_hit | output | 1 | Lookup found its mapping |
| rs_miss | output | 1 | Lookup found no mapping |
| rs_fault | output | 1 | Write refused on a protected page |
| rs_dirty | output | 1 | Dirty flag of the hit mapping after this access |
| rs_paddr | output | 16 | Translated physical address |

## Verification
A lookup and a state change can be accepted at the same edge. The state change may be a flush-all, a fill of the very key being looked up, or a fill issued together with a flush. The bench drives these pairs in a single cycle and judges the result from the port side. The response from that edge must reflect the old contents: a hit before the flush, or a miss before the fill. The lookup that follows must show the new contents. The pairing of a fill with a flush is judged in the same way: a lookup afterwards must still hit the freshly filled mapping.

// File: rtl/ptag_tlb_pkg.sv
package ptag_tlb_pkg;
   // Where an incoming fill is placed
   typedef enum logic [1:0] {
      SRC_MATCH = 2'd0,   // same key already present: overwrite it
      SRC_FREE  = 2'd1,   // lowest empty slot
      SRC_RR    = 2'd2    // all slots full: replacement pointer
   } fill_src_e;
endpackage

// File: rtl/ptag_tlb_cam.sv
module ptag_tlb_cam #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 6,
   parameter int PID_W   = 8,
   parameter int IDX_W   = 3
) (
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [VPN_W-1:0]   vpn_tbl [ENTRIES],
   input  logic [PID_W-1:0]   pid_tbl [ENTRIES],
   input  logic [VPN_W-1:0]   key_vpn,
   input  logic [PID_W-1:0]   key_pid,
   output logic [ENTRIES-1:0] match_vec,
   output logic [IDX_W-1:0]   match_idx
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match_vec[e] = valid_vec[e] &&
                            (vpn_tbl[e] == key_vpn) &&
                            (pid_tbl[e] == key_pid);
   end

   // Encode the matching slot; lowest index wins if ever more than one
   always_comb begin
      match_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (match_vec[e]) match_idx = IDX_W'(e);
      end
   end
endmodule

// File: rtl/ptag_tlb_victim.sv
module ptag_tlb_victim
   import ptag_tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               hit_any,
   input  logic [IDX_W-1:0]   hit_idx,
   input  logic               fill_en,
   output logic [IDX_W-1:0]   victim_idx
);
   logic             free_any;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] rr_ptr;
   fill_src_e        src;

   assign free_any = ~&valid_vec;

   always_comb begin
      free_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!valid_vec[e]) free_idx = IDX_W'(e);
      end
   end

   always_comb begin
      if (hit_any)       src = SRC_MATCH;
      else if (free_any) src = SRC_FREE;
      else               src = SRC_RR;
   end

   always_comb begin
      unique case (src)
         SRC_MATCH: victim_idx = hit_idx;
         SRC_FREE:  victim_idx = free_idx;
         default:   victim_idx = rr_ptr;
      endcase
   end

   if (ENTRIES > 1) begin : g_rr
      logic use_rr;
      assign use_rr = fill_en && (src == SRC_RR);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       rr_ptr <= '0;
         else if (use_rr)  rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
   end else begin : g_single
      assign rr_ptr = '0;
   end
endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb #(
   parameter int VA_W    = 16,
   parameter int VPN_W   = 6,
   parameter int FRAME_W = 6,
   parameter int PID_W   = 8,
   parameter int ENTRIES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic               lk_write,
   input  logic [VA_W-1:0]    lk_vaddr,
   input  logic [PID_W-1:0]   lk_pid,
   input  logic               fill_en,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [PID_W-1:0]   fill_pid,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic               fill_wprot,
   input  logic               flush_all,
   input  logic               flush_pid_en,
   input  logic [PID_W-1:0]   flush_pid,
   output logic               rs_valid,
   output logic               rs_hit,
   output logic               rs_miss,
   output logic               rs_fault,
   output logic               rs_dirty,
   output logic [FRAME_W+VA_W-VPN_W-1:0] rs_paddr
);
   localparam int OFF_W = VA_W - VPN_W;
   localparam int PA_W  = FRAME_W + OFF_W;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   // Elaboration-time parameter checks
   if (VPN_W < 1 || VPN_W >= VA_W) begin : g_bad_split
      $error("ptag_tlb: page field must be narrower than the address");
   end
   if (ENTRIES < 1 || PID_W < 1 || FRAME_W < 1) begin : g_bad_size
      $error("ptag_tlb: entries, identifier and frame widths must be positive");
   end

   // Mapping storage
   logic [ENTRIES-1:0] ent_valid, ent_dirty, ent_wprot;
   logic [VPN_W-1:0]   ent_vpn   [ENTRIES];
   logic [PID_W-1:0]   ent_pid   [ENTRIES];
   logic [FRAME_W-1:0] ent_frame [ENTRIES];

   // Lookup side
   logic [ENTRIES-1:0] lk_match_vec;
   logic [IDX_W-1:0]   lk_idx;
   logic               lk_hit, lk_wp, lk_fault, lk_set_dirty;

   ptag_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) u_lk_cam (
      .valid_vec (ent_valid),
      .vpn_tbl   (ent_vpn),
      .pid_tbl   (ent_pid),
      .key_vpn   (lk_vaddr[VA_W-1:OFF_W]),
      .key_pid   (lk_pid),
      .match_vec (lk_match_vec),
      .match_idx (lk_idx)
   );

   assign lk_hit       = lk_valid && (|lk_match_vec);
   assign lk_wp        = ent_wprot[lk_idx];
   assign lk_fault     = lk_hit && lk_write && lk_wp;
   assign lk_set_dirty = lk_hit && lk_write && !lk_wp;

   // Fill side
   logic [ENTRIES-1:0] fl_match_vec;
   logic [IDX_W-1:0]   fl_idx;
   logic [IDX_W-1:0]   victim_idx;

   ptag_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) u_fl_cam (
      .valid_vec (ent_valid),
      .vpn_tbl   (ent_vpn),
      .pid_tbl   (ent_pid),
      .key_vpn   (fill_vpn),
      .key_pid   (fill_pid),
      .match_vec (fl_match_vec),
      .match_idx (fl_idx)
   );

   ptag_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_vec  (ent_valid),
      .hit_any    (|fl_match_vec),
      .hit_idx    (fl_idx),
      .fill_en    (fill_en),
      .victim_idx (victim_idx)
   );

   // Entry update: the fill wins over flush and dirty marking on its slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_valid <= '0;
         ent_dirty <= '0;
         ent_wprot <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            ent_vpn[e]   <= '0;
            ent_pid[e]   <= '0;
            ent_frame[e] <= '0;
         end
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (fill_en && (victim_idx == IDX_W'(e))) begin
               ent_valid[e] <= 1'b1;
               ent_dirty[e] <= 1'b0;
               ent_wprot[e] <= fill_wprot;
               ent_vpn[e]   <= fill_vpn;
               ent_pid[e]   <= fill_pid;
               ent_frame[e] <= fill_frame;
            end else begin
               if (flush_all || (flush_pid_en && (ent_pid[e] == flush_pid)))
                  ent_valid[e] <= 1'b0;
               if (lk_set_dirty && (lk_idx == IDX_W'(e)))
                  ent_dirty[e] <= 1'b1;
            end
         end
      end
   end

   // Registered response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_miss  <= 1'b0;
         rs_fault <= 1'b0;
         rs_dirty <= 1'b0;
         rs_paddr <= '0;
      end else begin
         rs_valid <= lk_valid;
         rs_hit   <= lk_hit;
         rs_miss  <= lk_valid && !lk_hit;
         rs_fault <= lk_fault;
         rs_dirty <= lk_hit && (ent_dirty[lk_idx] || lk_set_dirty);
         rs_paddr <= lk_hit ? PA_W'({ent_frame[lk_idx], lk_vaddr[OFF_W-1:0]}) : '0;
      end
   end
endmodule

// File: rtl/ptag_tlb_chk.sv
module ptag_tlb_chk #(
   parameter int OFF_W   = 10,
   parameter int PA_W    = 16,
   parameter int VA_W    = 16,
   parameter int ENTRIES = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               lk_write,
   input logic [VA_W-1:0]    lk_vaddr,
   input logic               fill_en,
   input logic               flush_all,
   input logic               rs_valid,
   input logic               rs_hit,
   input logic               rs_miss,
   input logic               rs_fault,
   input logic               rs_dirty,
   input logic [PA_W-1:0]    rs_paddr,
   input logic [ENTRIES-1:0] ent_valid,
   input logic [ENTRIES-1:0] lk_match_vec
);
   p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!rs_hit || rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

   p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid);

   p_no_resp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rs_valid);

   p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match_vec));

   p_hit_xor_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid |-> (rs_hit != rs_miss));

   p_miss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rs_miss |-> (rs_paddr == '0 && !rs_fault && !rs_dirty));

   p_fault_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rs_fault |-> (rs_hit && $past(lk_write)));

   p_fault_not_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rs_fault |-> !rs_dirty);

   p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all && !fill_en) |=> (ent_valid == '0));
endmodule

bind ptag_tlb ptag_tlb_chk #(
   .OFF_W(OFF_W), .PA_W(PA_W), .VA_W(VA_W), .ENTRIES(ENTRIES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lk_valid     (lk_valid),
   .lk_write     (lk_write),
   .lk_vaddr     (lk_vaddr),
   .fill_en      (fill_en),
   .flush_all    (flush_all),
   .rs_valid     (rs_valid),
   .rs_hit       (rs_hit),
   .rs_miss      (rs_miss),
   .rs_fault     (rs_fault),
   .rs_dirty     (rs_dirty),
   .rs_paddr     (rs_paddr),
   .ent_valid    (ent_valid),
   .lk_match_vec (lk_match_vec)
);

// File: tb/ptag_tlb_tb.sv
module ptag_tlb_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_valid, lk_write;
   logic [15:0] lk_vaddr;
   logic [7:0]  lk_pid;
   logic        fill_en;
   logic [5:0]  fill_vpn;
   logic [7:0]  fill_pid;
   logic [5:0]  fill_frame;
   logic        fill_wprot;
   logic        flush_all, flush_pid_en;
   logic [7:0]  flush_pid;
   logic        rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty;
   logic [15:0] rs_paddr;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   ptag_tlb u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
      .fill_frame(fill_frame), .fill_wprot(fill_wprot),
      .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss),
      .rs_fault(rs_fault), .rs_dirty(rs_dirty), .rs_paddr(rs_paddr)
   );

   typedef struct packed {
      logic       is_fill;
      logic       wr;
      logic [5:0] vpn;
      logic [9:0] off;
      logic [7:0] pid;
      logic [5:0] frame;
      logic       wp;
      logic       hit;
      logic       flt;
      logic       dty;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 6'd3, 10'h000, 8'd1, 6'h2A, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // fill -> slot 0
      '{1'b1, 1'b0, 6'd3, 10'h000, 8'd2, 6'h15, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // fill -> slot 1, protected
      '{1'b0, 1'b0, 6'd3, 10'h1DE, 8'd1, 6'h2A, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 read hit
      '{1'b0, 1'b0, 6'd3, 10'h3FF, 8'd2, 6'h15, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 read on protected, top offset
      '{1'b0, 1'b1, 6'd3, 10'h000, 8'd2, 6'h15, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 write refused
      '{1'b0, 1'b1, 6'd3, 10'h005, 8'd1, 6'h2A, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 write sets dirty
      '{1'b0, 1'b0, 6'd3, 10'h100, 8'd1, 6'h2A, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 dirty kept
      '{1'b0, 1'b0, 6'd3, 10'h001, 8'd3, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 other process misses
      '{1'b0, 1'b0, 6'd4, 10'h001, 8'd1, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 plain miss
      '{1'b1, 1'b0, 6'd3, 10'h000, 8'd1, 6'h07, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 refill same key
      '{1'b0, 1'b0, 6'd3, 10'h2C4, 8'd1, 6'h07, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7}   // R7 overwritten, R6 dirty cleared
   };

   function automatic logic [20:0] exp_word(input logic hit, input logic flt,
                                            input logic dty, input logic [5:0] frame,
                                            input logic [9:0] off);
      return {1'b1, hit, !hit, hit & flt, hit & dty, hit ? {frame, off} : 16'h0};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] expv);
      n_chk++;
      if (got !== expv) begin
         n_err++;
         $display("FAIL %s got=%h expected=%h", req, got, expv);
      end
   endtask

   task automatic do_fill(input logic [5:0] vpn, input logic [7:0] pid,
                          input logic [5:0] frame, input logic wp);
      fill_en = 1'b1; fill_vpn = vpn; fill_pid = pid; fill_frame = frame; fill_wprot = wp;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic do_look(input logic wr, input logic [5:0] vpn, input logic [9:0] off,
                          input logic [7:0] pid, output logic [20:0] got);
      lk_valid = 1'b1; lk_write = wr; lk_vaddr = {vpn, off}; lk_pid = pid;
      @(negedge clk);
      lk_valid = 1'b0; lk_write = 1'b0;
      got = {rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty, rs_paddr};
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [20:0] g;
      rst_n = 1'b0;
      lk_valid = 1'b0; lk_write = 1'b0; lk_vaddr = '0; lk_pid = '0;
      fill_en = 1'b0; fill_vpn = '0; fill_pid = '0; fill_frame = '0; fill_wprot = 1'b0;
      flush_all = 1'b0; flush_pid_en = 1'b0; flush_pid = '0;
      repeat (3) @(negedge clk);
      // R11 outputs cleared in reset
      check("R11", 32'({rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty, rs_paddr}), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 empty after reset
      do_look(1'b0, 6'd3, 10'h0, 8'd1, g);
      check("R11", 32'(g), 32'(exp_word(1'b0, 1'b0, 1'b0, 6'h0, 10'h0)));
      // R2 nothing follows an idle cycle
      @(negedge clk);
      check("R2", 32'(rs_valid), 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_fill) begin
            do_fill(VECS[i].vpn, VECS[i].pid, VECS[i].frame, VECS[i].wp);
         end else begin
            do_look(VECS[i].wr, VECS[i].vpn, VECS[i].off, VECS[i].pid, g);
            check($sformatf("R%0d row %0d", VECS[i].req, i), 32'(g),
                  32'(exp_word(VECS[i].hit, VECS[i].flt, VECS[i].dty, VECS[i].frame, VECS[i].off)));
         end
      end

      // R9 flush one process only
      flush_pid_en = 1'b1; flush_pid = 8'd2;
      @(negedge clk);
      flush_pid_en = 1'b0;
      do_look(1'b0, 6'd3, 10'h00A, 8'd2, g);
      check("R9 flushed process", 32'(g), 32'(exp_word(1'b0, 1'b0, 1'b0, 6'h0, 10'h0)));
      do_look(1'b0, 6'd3, 10'h00A, 8'd1, g);
      check("R9 other process kept", 32'(g), 32'(exp_word(1'b1, 1'b0, 1'b0, 6'h07, 10'h00A)));

      // R10 lookup and flush_all at the same edge: answer from old contents
      lk_valid = 1'b1; lk_write = 1'b0; lk_vaddr = {6'd3, 10'h0F0}; lk_pid = 8'd1;
      flush_all = 1'b1;
      @(negedge clk);
      lk_valid = 1'b0; flush_all = 1'b0;
      check("R10 lookup with flush", 32'({rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty, rs_paddr}),
            32'(exp_word(1'b1, 1'b0, 1'b0, 6'h07, 10'h0F0)));
      // R8 everything gone
      do_look(1'b0, 6'd3, 10'h0F0, 8'd1, g);
      check("R8", 32'(g), 32'(exp_word(1'b0, 1'b0, 1'b0, 6'h0, 10'h0)));

      // R10 lookup of the key being filled at the same edge misses, then hits
      lk_valid = 1'b1; lk_vaddr = {6'd9, 10'h011}; lk_pid = 8'd5;
      fill_en = 1'b1; fill_vpn = 6'd9; fill_pid = 8'd5; fill_frame = 6'h33; fill_wprot = 1'b0;
      @(negedge clk);
      lk_valid = 1'b0; fill_en = 1'b0;
      check("R10 lookup with fill", 32'({rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty, rs_paddr}),
            32'(exp_word(1'b0, 1'b0, 1'b0, 6'h0, 10'h0)));
      do_look(1'b0, 6'd9, 10'h011, 8'd5, g);
      check("R10 fill visible next", 32'(g), 32'(exp_word(1'b1, 1'b0, 1'b0, 6'h33, 10'h011)));

      // R10 fill together with flush_all is kept
      flush_all = 1'b1;
      do_fill(6'd12, 8'd6, 6'h21, 1'b0);
      flush_all = 1'b0;
      do_look(1'b0, 6'd12, 10'h3C0, 8'd6, g);
      check("R10 fill with flush kept", 32'(g), 32'(exp_word(1'b1, 1'b0, 1'b0, 6'h21, 10'h3C0)));
      do_look(1'b0, 6'd9, 10'h011, 8'd5, g);
      check("R8 old mapping flushed", 32'(g), 32'(exp_word(1'b0, 1'b0, 1'b0, 6'h0, 10'h0)));

      // R7 replacement order once full (pointer never used so far, so it is 0)
      flush_all = 1'b1;
      @(negedge clk);
      flush_all = 1'b0;
      for (int k = 0; k < 8; k++) do_fill(6'(10 + k), 8'd7, 6'(10 + k), 1'b0);
      do_fill(6'd20, 8'd7, 6'd20, 1'b0);
      do_look(1'b0, 6'd10, 10'h0, 8'd7, g);
      check("R7 slot 0 replaced", 32'(g), 32'(exp_word(1'b0, 1'b0, 1'b0, 6'h0, 10'h0)));
      do_look(1'b0, 6'd11, 10'h1, 8'd7, g);
      check("R7 slot 1 kept", 32'(g), 32'(exp_word(1'b1, 1'b0, 1'b0, 6'd11, 10'h1)));
      do_fill(6'd21, 8'd7, 6'd21, 1'b0);
      do_look(1'b0, 6'd11, 10'h1, 8'd7, g);
      check("R7 slot 1 replaced next", 32'(g), 32'(exp_word(1'b0, 1'b0, 1'b0, 6'h0, 10'h0)));
      do_look(1'b0, 6'd12, 10'h2, 8'd7, g);
      check("R7 slot 2 kept", 32'(g), 32'(exp_word(1'b1, 1'b0, 1'b0, 6'd12, 10'h2)));
      do_look(1'b0, 6'd21, 10'h3, 8'd7, g);
      check("R7 new mapping present", 32'(g), 32'(exp_word(1'b1, 1'b0, 1'b0, 6'd21, 10'h3)));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule